// File: doc/BRIEF.md
# Unaligned 128-bit Load Aligner

This block serves 16-byte load requests that may start at any byte address, while the memory behind it only ever sees reads on 16-byte boundaries. A request whose address has its four low bits clear costs a single aligned read. Any other address costs two aligned reads: the 16-byte block at or below the address, and then the block right after it. The bytes wanted are then cut out of the 32-byte window that those two reads form.

A client presents an address with a valid/ready handshake. The block drives an aligned read address and enable toward a memory port whose data comes back one cycle after the enable. The block presents the assembled 16 bytes with a one-cycle valid pulse. Only one request is in flight at a time. The next request is taken in the cycle after the response.

Top module: `ualign_load`

## Requirements
- R1: When the request address has bits [3:0] equal to zero, exactly one memory read is issued, at the request address, and `rsp_valid` rises in the second cycle after the accepting clock edge.
- R2: When bits [3:0] of the address are nonzero, exactly two memory reads are issued in consecutive cycles: the first at the address with bits [3:0] cleared (the base), the second at base + 16. `rsp_valid` rises in the third cycle after the accepting edge.
- R3: Response byte k (bits 8k+7:8k of `rsp_data`) equals the memory byte at request address + k, for k = 0..15. Memory data byte j of a read at address A sits at bits 8j+7:8j and holds the byte at A + j.
- R4: Every issued memory read address has bits [3:0] equal to zero.
- R5: Data for a read is taken from `mem_rd_data` in the cycle after `mem_rd_en` was high. Contents written to memory between requests are reflected in the next response.
- R6: `req_ready` is high in the idle state and stays low from the accepting edge until the response has been presented. A request held during that time is neither taken nor able to alter the pending response.
- R7: `rsp_valid` is high for exactly one cycle per accepted request, and `req_ready` is high again in the following cycle.
- R8: While `rst_n` is low, and right after it is released, `req_ready` is high and `rsp_valid` and `mem_rd_en` are low. Reset in mid-request abandons that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the 16-byte load |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Aligned memory read address |
| mem_rd_data | input | 128 | Read data, valid one cycle after the strobe |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 128 | Assembled 16 bytes, byte 0 at the request address |

## Verification
A wrong state in the controller shows at the ports within one to three cycles of the accepting edge. The possible symptoms are a missing or extra read strobe, a second read that is not at base + 16, a response pulse one cycle early or late, or `req_ready` rising while a request is pending. A stale lower block or a wrong offset shows up as byte-level corruption in `rsp_data` at that same response. Because of this, every offset from 0 to 15 is compared byte by byte against a memory model, and the number of reads and the response cycle are counted for each request.

// File: rtl/ualign_load.sv
module ualign_load #(
  parameter int ADDR_W     = 32,
  parameter int LANE_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  output logic                    mem_rd_en,
  output logic [ADDR_W-1:0]       mem_rd_addr,
  input  logic [LANE_BYTES*8-1:0] mem_rd_data,
  output logic                    rsp_valid,
  output logic [LANE_BYTES*8-1:0] rsp_data
);
  localparam int LANE_W = LANE_BYTES * 8;
  localparam int OFF_W  = $clog2(LANE_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_READ_LO, S_READ_HI, S_RESPOND} state_t;

  state_t              state_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [LANE_W-1:0]   lo_q;
  logic [ADDR_W-1:0]   base;
  logic [OFF_W-1:0]    offset;
  logic                aligned;
  logic [2*LANE_W-1:0] window;

  assign offset  = addr_q[OFF_W-1:0];
  assign aligned = (offset == '0);
  assign base    = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  assign req_ready   = (state_q == S_IDLE);
  assign rsp_valid   = (state_q == S_RESPOND);
  assign mem_rd_en   = (state_q == S_READ_LO) || (state_q == S_READ_HI);
  assign mem_rd_addr = (state_q == S_READ_HI) ? base + ADDR_W'(LANE_BYTES) : base;

  assign window = {mem_rd_data, aligned ? mem_rd_data : lo_q};

  always_comb begin
    for (int b = 0; b < LANE_BYTES; b++) begin
      rsp_data[b*8 +: 8] = window[(int'(offset) + b)*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      lo_q    <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          state_q <= S_READ_LO;
        end
        S_READ_LO: state_q <= aligned ? S_RESPOND : S_READ_HI;
        S_READ_HI: begin
          lo_q    <= mem_rd_data;
          state_q <= S_RESPOND;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_rd_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_rd_addr[OFF_W-1:0] == '0));

  p_hi_after_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(LANE_BYTES)));

  p_aligned_one_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[OFF_W-1:0] == '0) |=>
      (mem_rd_en && mem_rd_addr == $past(req_addr)) ##1 (!mem_rd_en && rsp_valid));

  p_unaligned_two_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[OFF_W-1:0] != '0) |=>
      mem_rd_en ##1 mem_rd_en ##1 (!mem_rd_en && rsp_valid));

  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !mem_rd_en));
endmodule

// File: tb/ualign_load_tb.sv
module ualign_load_tb_top;
  localparam int ADDR_W = 32;
  localparam int NV     = 20;
  localparam int unsigned VEC_ADDR [NV] = '{
    'h30, 'h37, 'h3F, 'h31, 'h38, 'h3E, 'h32, 'h39,
    'h3D, 'h33, 'h3A, 'h3C, 'h34, 'h3B, 'h35, 'h36,
    'h80, 'h9F, 'hF8, 'h00};
  localparam int VEC_LAT [NV] = '{
    2, 3, 3, 3, 3, 3, 3, 3,
    3, 3, 3, 3, 3, 3, 3, 3,
    2, 3, 3, 2};

  logic              clk = 0;
  logic              rst_n = 0;
  logic              req_valid = 0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              mem_rd_en;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic [127:0]      mem_rd_data = '0;
  logic              rsp_valid;
  logic [127:0]      rsp_data;

  logic [7:0]        mem_b [256];
  int                n_chk = 0, n_bad = 0, rd_cnt = 0;
  logic [ADDR_W-1:0] rd_a0, rd_a1;
  bit                done = 0;

  always #5 clk = ~clk;

  ualign_load #(.ADDR_W(ADDR_W), .LANE_BYTES(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  always @(posedge clk)
    if (mem_rd_en)
      for (int k = 0; k < 16; k++) mem_rd_data[k*8 +: 8] <= mem_b[8'(mem_rd_addr[7:0] + 8'(k))];

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && mem_rd_en) begin
      if (rd_cnt == 0) rd_a0 = mem_rd_addr;
      if (rd_cnt == 1) rd_a1 = mem_rd_addr;
      rd_cnt++;
      check(mem_rd_addr[3:0] == 4'h0, "R4 read address aligned", 128'(mem_rd_addr), 128'(mem_rd_addr & ~32'hF));
    end

  function automatic logic [127:0] expect_at(input logic [ADDR_W-1:0] a);
    logic [127:0] e;
    for (int k = 0; k < 16; k++) e[k*8 +: 8] = mem_b[8'(a[7:0] + 8'(k))];
    return e;
  endfunction

  task automatic seed(input logic [7:0] x);
    for (int i = 0; i < 256; i++) mem_b[i] = 8'(i * 37 + 11) ^ x;
  endtask

  task automatic do_req(input logic [ADDR_W-1:0] a, input int lat);
    int cyc;
    logic [ADDR_W-1:0] base;
    base = a & ~32'hF;
    @(negedge clk);
    check(req_ready == 1'b1, "R6 ready when idle", 128'(req_ready), 128'(1));
    req_valid = 1; req_addr = a; rd_cnt = 0;
    @(negedge clk);
    req_valid = 0;
    cyc = 1;
    check(req_ready == 1'b0, "R6 busy after accept", 128'(req_ready), 128'(0));
    while (!rsp_valid && cyc < 10) begin
      @(negedge clk);
      cyc++;
      if (!rsp_valid) check(req_ready == 1'b0, "R6 busy until response", 128'(req_ready), 128'(0));
    end
    check(cyc == lat, (lat == 2) ? "R1 aligned response cycle" : "R2 unaligned response cycle", 128'(cyc), 128'(lat));
    check(rd_cnt == lat - 1, (lat == 2) ? "R1 single read" : "R2 two reads", 128'(rd_cnt), 128'(lat - 1));
    check(rd_a0 == base, "R1 R2 first read at base", 128'(rd_a0), 128'(base));
    if (lat == 3) check(rd_a1 == base + 16, "R2 second read at base+16", 128'(rd_a1), 128'(base + 16));
    check(rsp_data == expect_at(a), "R3 R5 response bytes", rsp_data, expect_at(a));
    @(negedge clk);
    check(!rsp_valid && req_ready, "R7 single-cycle response", 128'({rsp_valid, req_ready}), 128'(2'b01));
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    seed(8'h00);
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_rd_en, "R8 reset outputs", 128'({req_ready, rsp_valid, mem_rd_en}), 128'(3'b100));
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !mem_rd_en, "R8 after release", 128'({req_ready, rsp_valid, mem_rd_en}), 128'(3'b100));

    for (int v = 0; v < NV; v++) do_req(VEC_ADDR[v], VEC_LAT[v]);

    // R5: memory rewritten between requests must be seen
    seed(8'h5A);
    do_req('h47, 3);
    do_req('hA0, 2);

    // R6: request held high while busy is not taken and does not disturb the response
    @(negedge clk);
    req_valid = 1; req_addr = 'h13;
    @(negedge clk);
    req_addr = 'h60;
    check(!req_ready, "R6 held request not taken", 128'(req_ready), 128'(0));
    @(negedge clk);
    check(!req_ready, "R6 held request not taken", 128'(req_ready), 128'(0));
    @(negedge clk);
    check(rsp_valid && rsp_data == expect_at('h13), "R6 pending response unchanged", rsp_data, expect_at('h13));
    req_valid = 0;
    @(negedge clk);
    check(req_ready, "R7 ready after response", 128'(req_ready), 128'(1));

    // R8: reset in mid-request abandons it
    req_valid = 1; req_addr = 'h25;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check(req_ready && !rsp_valid && !mem_rd_en, "R8 reset mid-request", 128'({req_ready, rsp_valid, mem_rd_en}), 128'(3'b100));
    rst_n = 1;
    @(negedge clk);
    check(!rsp_valid && req_ready, "R8 request abandoned", 128'({rsp_valid, req_ready}), 128'(2'b01));
    do_req('h5C, 3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule